// File: doc/BRIEF.md
# Audio Serial Clock Generator

This block derives the clocks of a serial audio link from one source clock. A primary divider splits the source by a ratio of twice an integer field plus an optional odd step. Its output can be driven out as the master clock. A bit clock and a word-select strobe for the left/right channel framing follow from the same divider.

All outputs are registered signals in the source-clock domain. Configuration (divide field, odd step, master-clock enable, channel length) is captured only while the enable input is low and is frozen while the block runs. Raising the enable restarts every counter in a known phase, so software reconfigures by dropping the enable, writing new settings and raising it again.

When the master clock is off, the bit clock is the primary divider output itself. When the master clock is on, a post-divider slows the bit clock by 8 for 16-bit channels or by 4 for 32-bit channels. The sample rate then becomes the source divided by 256 times the ratio in both cases.

Top module: `asclk_gen`

## Requirements
- R1: The primary ratio is r = 2*DIV + ODD; any value below 2 is clamped to 2, so DIV=0 with ODD=0 or ODD=1 gives r=2.
- R2: Counting t from 0 at the first clock edge where the enable is sampled high, the primary phase is high when (t mod r) < ceil(r/2) and low otherwise, so an odd ratio is high one source cycle longer than it is low.
- R3: With the master-clock enable at 0, the master-clock output stays low and the bit clock equals the primary phase, with period r.
- R4: With the master-clock enable at 1, the master-clock output equals the primary phase.
- R5: With the master-clock enable at 1 and the channel-length bit at 0, the bit clock is high when (t mod 8r) < 4r, giving a period of 8r.
- R6: With the master-clock enable at 1 and the channel-length bit at 1, the bit clock is high when (t mod 4r) < 2r, giving a period of 4r.
- R7: Word select starts low and toggles in the same cycle as every 16th falling bit-clock edge (channel-length bit 0) or every 32nd (channel-length bit 1).
- R8: Once the enable is sampled low, all three outputs are low from the next cycle on.
- R9: Changes on the divide field, odd step, master-clock enable or channel-length inputs while the enable is high do not alter any output until the block is disabled and enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| en | input | 1 | Run enable; low also opens configuration capture |
| div_i | input | DIV_W | Integer half of the divide ratio |
| odd_i | input | 1 | Adds one to the ratio |
| mcken_i | input | 1 | Master-clock output enable |
| chlen_i | input | 1 | Channel length: 0 = 16 bits, 1 = 32 bits |
| bclk_o | output | 1 | Bit clock |
| mck_o | output | 1 | Master clock |
| ws_o | output | 1 | Word-select strobe |

## Verification
Each output is a registered function of the cycle index t counted from the first edge that samples the enable high. The value for t = 0 is therefore visible one edge after the enable is raised, and every later value appears exactly one cycle apart. The bench raises the enable on a falling edge and samples all outputs on each following falling edge, comparing them against closed-form expressions in t. Disable behaviour is checked one edge after the enable drops. Configuration disturbance is applied mid-run, while expectations keep using the captured settings.

// File: rtl/asclk_pkg.sv
package asclk_pkg;

  // Effective primary ratio with the lower clamp applied.
  function automatic int unsigned eff_ratio(input int unsigned div, input logic odd);
    int unsigned r;
    r = 2 * div + (odd ? 1 : 0);
    return (r < 2) ? 2 : r;
  endfunction

  // Length of the high phase (ceiling half).
  function automatic int unsigned phase_hi(input int unsigned r);
    return (r + 1) / 2;
  endfunction

  // Length of the low phase (floor half).
  function automatic int unsigned phase_lo(input int unsigned r);
    return r / 2;
  endfunction

  // Primary periods per half bit clock when the post-divider is active.
  function automatic int unsigned post_half(input logic chlen, input int unsigned short_div,
                                            input int unsigned long_div);
    return chlen ? (long_div / 2) : (short_div / 2);
  endfunction

  // Bit-clock falls per word-select half frame.
  function automatic int unsigned frame_len(input logic chlen, input int unsigned short_len,
                                            input int unsigned long_len);
    return chlen ? long_len : short_len;
  endfunction

endpackage

// File: rtl/asclk_cfg.sv
module asclk_cfg #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div_i,
  input  logic             odd_i,
  input  logic             mcken_i,
  input  logic             chlen_i,
  output logic [DIV_W-1:0] div_q,
  output logic             odd_q,
  output logic             mcken_q,
  output logic             chlen_q,
  output logic             run_q,
  output logic             start
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      odd_q   <= 1'b0;
      mcken_q <= 1'b0;
      chlen_q <= 1'b0;
      run_q   <= 1'b0;
    end else begin
      run_q <= en;
      if (!en) begin
        div_q   <= div_i;
        odd_q   <= odd_i;
        mcken_q <= mcken_i;
        chlen_q <= chlen_i;
      end
    end
  end

  assign start = en && !run_q;

endmodule

// File: rtl/asclk_prediv.sv
module asclk_prediv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  input  logic             odd,
  output logic             p_hi,
  output logic             rise_ev,
  output logic             fall_ev,
  output logic [DIV_W:0]   cnt,
  output logic [DIV_W:0]   hi_len
);

  localparam int CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] lo_len;
  logic             wrap;

  always_comb begin
    int unsigned r;
    r      = asclk_pkg::eff_ratio(int'(div), odd);
    hi_len = CNT_W'(asclk_pkg::phase_hi(r));
    lo_len = CNT_W'(asclk_pkg::phase_lo(r));
  end

  assign wrap    = en && run && (cnt == '0);
  assign rise_ev = wrap && !p_hi;
  assign fall_ev = wrap && p_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_hi <= 1'b0;
      cnt  <= '0;
    end else if (!en) begin
      p_hi <= 1'b0;
      cnt  <= '0;
    end else if (!run) begin
      p_hi <= 1'b1;
      cnt  <= hi_len - 1'b1;
    end else if (cnt == '0) begin
      p_hi <= !p_hi;
      cnt  <= (p_hi ? lo_len : hi_len) - 1'b1;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/asclk_postdiv.sv
module asclk_postdiv #(
  parameter int SHORT_POST = 8,
  parameter int LONG_POST  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic start,
  input  logic mcken,
  input  logic chlen,
  input  logic rise_ev,
  input  logic fall_ev,
  output logic bclk,
  output logic bclk_fall
);

  localparam int MAX_POST = (SHORT_POST > LONG_POST) ? SHORT_POST : LONG_POST;
  localparam int PC_W     = $clog2(MAX_POST) + 1;

  logic [PC_W-1:0] pc, pc_d, half_m1;
  logic            bclk_d;

  assign half_m1 = PC_W'(asclk_pkg::post_half(chlen, SHORT_POST, LONG_POST) - 1);

  always_comb begin
    bclk_d = bclk;
    pc_d   = pc;
    if (!en) begin
      bclk_d = 1'b0;
      pc_d   = '0;
    end else if (start) begin
      bclk_d = 1'b1;
      pc_d   = '0;
    end else if (!mcken) begin
      if (rise_ev) bclk_d = 1'b1;
      if (fall_ev) bclk_d = 1'b0;
    end else if (rise_ev) begin
      if (pc == half_m1) begin
        pc_d   = '0;
        bclk_d = !bclk;
      end else begin
        pc_d = pc + 1'b1;
      end
    end
  end

  assign bclk_fall = en && bclk && !bclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk <= 1'b0;
      pc   <= '0;
    end else begin
      bclk <= bclk_d;
      pc   <= pc_d;
    end
  end

endmodule

// File: rtl/asclk_ws.sv
module asclk_ws #(
  parameter int SHORT_FRAME = 16,
  parameter int LONG_FRAME  = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic start,
  input  logic chlen,
  input  logic bclk_fall,
  output logic ws
);

  localparam int MAX_F = (SHORT_FRAME > LONG_FRAME) ? SHORT_FRAME : LONG_FRAME;
  localparam int WC_W  = $clog2(MAX_F) + 1;

  logic [WC_W-1:0] wc, len_m1;

  assign len_m1 = WC_W'(asclk_pkg::frame_len(chlen, SHORT_FRAME, LONG_FRAME) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws <= 1'b0;
      wc <= '0;
    end else if (!en || start) begin
      ws <= 1'b0;
      wc <= '0;
    end else if (bclk_fall) begin
      if (wc == len_m1) begin
        wc <= '0;
        ws <= !ws;
      end else begin
        wc <= wc + 1'b1;
      end
    end
  end

endmodule

// File: rtl/asclk_gen.sv
module asclk_gen #(
  parameter int DIV_W       = 8,
  parameter int SHORT_POST  = 8,
  parameter int LONG_POST   = 4,
  parameter int SHORT_FRAME = 16,
  parameter int LONG_FRAME  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div_i,
  input  logic             odd_i,
  input  logic             mcken_i,
  input  logic             chlen_i,
  output logic             bclk_o,
  output logic             mck_o,
  output logic             ws_o
);

  logic [DIV_W-1:0] cfg_div;
  logic             cfg_odd, cfg_mcken, cfg_chlen;
  logic             run, start;
  logic             prim_hi, prim_rise, prim_fall, bclk_fall;
  logic [DIV_W:0]   ph_cnt, ph_hi_len;

  asclk_cfg #(.DIV_W(DIV_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .en(en),
    .div_i(div_i), .odd_i(odd_i), .mcken_i(mcken_i), .chlen_i(chlen_i),
    .div_q(cfg_div), .odd_q(cfg_odd), .mcken_q(cfg_mcken), .chlen_q(cfg_chlen),
    .run_q(run), .start(start)
  );

  asclk_prediv #(.DIV_W(DIV_W)) u_prediv (
    .clk(clk), .rst_n(rst_n), .en(en), .run(run),
    .div(cfg_div), .odd(cfg_odd),
    .p_hi(prim_hi), .rise_ev(prim_rise), .fall_ev(prim_fall),
    .cnt(ph_cnt), .hi_len(ph_hi_len)
  );

  asclk_postdiv #(.SHORT_POST(SHORT_POST), .LONG_POST(LONG_POST)) u_postdiv (
    .clk(clk), .rst_n(rst_n), .en(en), .start(start),
    .mcken(cfg_mcken), .chlen(cfg_chlen),
    .rise_ev(prim_rise), .fall_ev(prim_fall),
    .bclk(bclk_o), .bclk_fall(bclk_fall)
  );

  asclk_ws #(.SHORT_FRAME(SHORT_FRAME), .LONG_FRAME(LONG_FRAME)) u_ws (
    .clk(clk), .rst_n(rst_n), .en(en), .start(start),
    .chlen(cfg_chlen), .bclk_fall(bclk_fall), .ws(ws_o)
  );

  assign mck_o = prim_hi && cfg_mcken;

endmodule

// File: rtl/asclk_gen_chk.sv
module asclk_gen_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             run,
  input logic [DIV_W-1:0] cfg_div,
  input logic             cfg_odd,
  input logic             cfg_mcken,
  input logic             cfg_chlen,
  input logic             prim_hi,
  input logic [DIV_W:0]   ph_cnt,
  input logic [DIV_W:0]   ph_hi_len,
  input logic             bclk_o,
  input logic             mck_o,
  input logic             ws_o
);

  // R8: outputs quiet one cycle after the enable is low
  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!bclk_o && !mck_o && !ws_o));

  // R3: master clock silent while its enable is off
  p_mck_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mcken |-> !mck_o);

  // R3: bit clock follows the primary phase without post-division
  p_bclk_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mcken |-> (bclk_o == prim_hi));

  // R9: captured settings frozen while running
  p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en) |-> $stable({cfg_div, cfg_odd, cfg_mcken, cfg_chlen}));

  // R7: word select only moves with a bit-clock fall
  p_ws_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && (ws_o != $past(ws_o))) |-> ($past(bclk_o) && !bclk_o));

  // R2: phase counter never exceeds the longer half
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && run) |-> (ph_cnt < ph_hi_len));

endmodule

bind asclk_gen asclk_gen_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .run(run),
  .cfg_div(cfg_div), .cfg_odd(cfg_odd), .cfg_mcken(cfg_mcken), .cfg_chlen(cfg_chlen),
  .prim_hi(prim_hi), .ph_cnt(ph_cnt), .ph_hi_len(ph_hi_len),
  .bclk_o(bclk_o), .mck_o(mck_o), .ws_o(ws_o)
);

// File: tb/asclk_gen_tb.sv
`timescale 1ns/1ps
module asclk_gen_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [7:0] div_i = '0;
  logic       odd_i = 1'b0, mcken_i = 1'b0, chlen_i = 1'b0;
  logic       bclk_o, mck_o, ws_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  asclk_gen u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .div_i(div_i), .odd_i(odd_i),
    .mcken_i(mcken_i), .chlen_i(chlen_i),
    .bclk_o(bclk_o), .mck_o(mck_o), .ws_o(ws_o)
  );

  function automatic int ratio_of(int d, bit o);
    int r = d + d + o;
    if (r < 2) r = 2;
    return r;
  endfunction

  function automatic bit exp_prim(int t, int r);
    return (t % r) < ((r + 1) / 2);
  endfunction

  function automatic bit exp_bclk(int t, int r, bit m, bit c);
    int n;
    if (!m) return exp_prim(t, r);
    n = c ? 4 : 8;
    return (t % (n * r)) < ((n / 2) * r);
  endfunction

  function automatic bit exp_ws(int t, int r, bit m, bit c);
    int per, high, falls, len;
    per  = m ? (c ? 4 * r : 8 * r) : r;
    high = m ? per / 2 : (r + 1) / 2;
    len  = c ? 32 : 16;
    falls = (t >= high) ? ((t - high) / per + 1) : 0;
    return ((falls / len) % 2) == 1;
  endfunction

  task automatic check(string req, bit act, bit expv, int t);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s t=%0d actual=%0b expected=%0b", req, t, act, expv);
    end
  endtask

  task automatic run_case(int d, bit o, bit m, bit c, bit disturb);
    int r, per, len, cycles;
    r   = ratio_of(d, o);
    per = m ? (c ? 4 * r : 8 * r) : r;
    len = c ? 32 : 16;
    cycles = 2 * len * per + per + 8;
    if (cycles > 20000) cycles = 20000;
    @(negedge clk);
    en = 1'b0; div_i = 8'(d); odd_i = o; mcken_i = m; chlen_i = c;
    repeat (3) @(negedge clk);
    check("R8 bclk idle", bclk_o, 1'b0, -1);
    check("R8 mck idle", mck_o, 1'b0, -1);
    check("R8 ws idle", ws_o, 1'b0, -1);
    en = 1'b1;
    for (int t = 0; t < cycles; t++) begin
      @(negedge clk);
      if (m) begin
        check("R4 mck", mck_o, exp_prim(t, r), t);
        check(c ? "R6 bclk" : "R5 bclk", bclk_o, exp_bclk(t, r, m, c), t);
      end else begin
        check("R3 mck low", mck_o, 1'b0, t);
        check("R1 R2 R3 bclk", bclk_o, exp_prim(t, r), t);
      end
      check("R7 ws", ws_o, exp_ws(t, r, m, c), t);
      if (disturb && t == cycles / 3) begin
        // R9: new settings while enabled must not matter
        div_i = 8'($urandom_range(0, 255)); odd_i = ~o; mcken_i = ~m; chlen_i = ~c;
      end
    end
    en = 1'b0;
    @(negedge clk);
    check("R8 bclk off", bclk_o, 1'b0, -1);
    check("R8 mck off", mck_o, 1'b0, -1);
    check("R8 ws off", ws_o, 1'b0, -1);
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    check("R8 reset bclk", bclk_o, 1'b0, -1);
    check("R8 reset mck", mck_o, 1'b0, -1);
    check("R8 reset ws", ws_o, 1'b0, -1);
    rst_n = 1'b1;
    // directed corners: R1 clamp, odd/even ratios, each mode
    run_case(0, 0, 0, 0, 0);
    run_case(0, 1, 1, 0, 1);
    run_case(1, 0, 0, 1, 0);
    run_case(1, 1, 0, 0, 1);
    run_case(3, 1, 1, 0, 1);
    run_case(2, 0, 1, 1, 1);
    run_case(255, 1, 0, 0, 1);
    for (int k = 0; k < 8; k++) begin
      run_case(int'($urandom_range(0, 9)), 1'($urandom_range(0, 1)),
               1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'b1);
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule